// File: doc/BRIEF.md
# Write-Only Serial Control Register Slave

This block is a slave-only, write-only receiver for a two-wire serial control bus. It samples the clock and data lines in the system clock domain, recognises START and STOP, and matches a 7-bit device address. Six bits of that address are fixed. The least significant bit comes from a strap input. A transaction carries exactly one data byte. The top three bits of that byte pick a control register, and the bottom five bits are the value written to it. The block drives the data line only through an active-high pull-low enable.

The registers drive the control fields of an amplifier-style front end:
- a mode field: power-on and the two input selects;
- diagnostic controls;
- a 5-bit fault-mask;
- two 5-bit volume settings.

While a hold input is high, for example during a power-up self-test, received writes are kept in a buffer. Each register keeps only the last value written to it. The buffered values are applied as soon as hold drops.

Top module: `i2cw_slave`

## Requirements
- R1: After reset every register output is zero and `sdaPullEn` is low.
- R2: The address byte carries seven address bits, MSB first, and then a direction bit. When the address equals `111110` followed by `addrStrap` and the direction bit is 0, the slave pulls the data line low during the ninth clock. Any other address gets no acknowledge, and the rest of that transaction changes nothing.
- R3: An address byte whose direction bit is 1 gets no acknowledge, and none of the following bytes changes a register.
- R4: After an acknowledged address, the slave acknowledges the data byte. Bits 7:5 of that byte select the register and bits 4:0 are the value. The register codes are 000 mode, 001 diagnostic, 010 `faultMask`, 011 `vol1` and 100 `vol2`.
- R5: For the mode register, value bit 4 drives `powerOn`, bit 3 drives `in2Sel` and bit 2 drives `in1Sel`. Bits 1:0 have no effect.
- R6: For the diagnostic register, value bit 4 drives `diagEn`, bit 3 drives `diagCont`, bit 2 drives `faultClr` and bit 1 drives `ilimMode`. Bit 0 has no effect.
- R7: A data byte with register code 101, 110 or 111 is acknowledged but changes no output.
- R8: While `holdApply` is high, the register outputs do not change. Each write received in that time is kept, and a later write to the same register replaces the earlier one. On the first clock with `holdApply` low, all kept values are applied.
- R9: A START or STOP that arrives before the eighth data bit aborts the transaction and leaves every register unchanged. A repeated START begins a new transaction.
- R10: Only one data byte is taken per transaction. Any later byte gets no acknowledge and changes nothing.
- R11: `sdaPullEn` changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| addrStrap | input | 1 | Least significant bit of the device address |
| holdApply | input | 1 | Defers applying received writes while high |
| sdaPullEn | output | 1 | High pulls the data line low (acknowledge) |
| powerOn | output | 1 | Mode: power on |
| in2Sel | output | 1 | Mode: input 2 selected |
| in1Sel | output | 1 | Mode: input 1 selected |
| diagEn | output | 1 | Diagnostic enable |
| diagCont | output | 1 | Continuous diagnostic mode |
| faultClr | output | 1 | Fault reset |
| ilimMode | output | 1 | Current-limit mode select |
| faultMask | output | 5 | Fault-mask value |
| vol1 | output | 5 | Volume setting 1 |
| vol2 | output | 5 | Volume setting 2 |

## Verification
A wrong bit counter or phase state shows up at `sdaPullEn` in the very next ninth clock: either an acknowledge is missing, or it lands one bit early or late. It can also leave the wrong byte committed, and that appears on the register outputs three system clocks after the eighth data rising edge. A stale or leaked hold buffer appears at the outputs either on the first clock after `holdApply` falls or while hold is still high. The bench therefore compares every register output against its own model on every clock.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int PAY_W    = 5;
  localparam int SEL_W    = 3;
  localparam int BYTE_W   = PAY_W + SEL_W;
  localparam int ADDR_W   = BYTE_W - 1;
  localparam int NUM_REGS = 5;
  localparam int CNT_W    = $clog2(BYTE_W);

  localparam int REG_MODE = 0;
  localparam int REG_DIAG = 1;
  localparam int REG_MASK = 2;
  localparam int REG_VOL1 = 3;
  localparam int REG_VOL2 = 4;

  typedef struct packed {
    logic shift;
    logic bitVal;
    logic commit;
  } strobe_t;

  // bits of each register that hold state; the rest read as zero
  function automatic logic [PAY_W-1:0] keepMask(input int idx);
    logic [PAY_W-1:0] m;
    m = '1;
    if (idx == REG_MODE) m[1:0] = 2'b00;
    if (idx == REG_DIAG) m[0] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
  import i2cw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  logic    addrOk,
  input  logic    addrRw,
  output strobe_t stb,
  output logic    sdaPullEn
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AEND, S_AACK, S_DATA, S_DEND, S_DACK, S_SKIP
  } phase_t;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startSeen, stopSeen;
  phase_t state;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS      = sclPipe[SYNC_STAGES-1];
  assign sdaS      = sdaPipe[SYNC_STAGES-1];
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startSeen = sclS & sclD & sdaD & ~sdaS;
  assign stopSeen  = sclS & sclD & ~sdaD & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitCnt <= '0;
    end else if (startSeen) begin
      state  <= S_ADDR;
      bitCnt <= '0;
    end else if (stopSeen) begin
      state  <= S_IDLE;
      bitCnt <= '0;
    end else begin
      unique case (state)
        S_ADDR: if (sclRise) begin
          if (bitCnt == LAST_BIT) state <= S_AEND;
          else bitCnt <= bitCnt + 1'b1;
        end
        S_AEND: if (sclFall) state <= addrOk ? S_AACK : S_SKIP;
        S_AACK: if (sclFall) begin
          state  <= S_DATA;
          bitCnt <= '0;
        end
        S_DATA: if (sclRise) begin
          if (bitCnt == LAST_BIT) state <= S_DEND;
          else bitCnt <= bitCnt + 1'b1;
        end
        S_DEND: if (sclFall) state <= S_DACK;
        S_DACK: if (sclFall) state <= S_SKIP;
        default: ;
      endcase
    end
  end

  always_comb begin
    stb.shift  = sclRise && (state == S_ADDR || state == S_DATA);
    stb.bitVal = sdaS;
    stb.commit = sclRise && state == S_DATA && bitCnt == LAST_BIT;
  end

  assign sdaPullEn = (state == S_AACK) || (state == S_DACK);

  // R2: a matching write address is acknowledged on the next cycle
  a_r2_ack_on_match: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_AEND && sclFall && addrOk && !startSeen && !stopSeen) |=> sdaPullEn);

  // R3: an address byte with the read bit set is never acknowledged
  a_r3_read_not_acked: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_AEND && sclFall && addrRw) |=> !sdaPullEn);

  // R11: the pull enable only moves while the synchronized clock is low
  a_r11_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaPullEn) || $fell(sdaPullEn)) |-> !sclS);
endmodule

// File: rtl/i2cw_regs.sv
module i2cw_regs
  import i2cw_pkg::*;
#(
  parameter logic [ADDR_W-2:0] DEV_HI = 6'b111110
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic                      addrStrap,
  input  logic                      holdApply,
  output logic                      addrOk,
  output logic                      addrRw,
  output logic [NUM_REGS*PAY_W-1:0] regFlat
);
  logic [BYTE_W-1:0] shiftReg, byteNow;
  logic [SEL_W-1:0]  selCode;
  logic [PAY_W-1:0]  payload;
  logic [NUM_REGS-1:0] pendVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (stb.shift) shiftReg <= byteNow;
  end

  assign byteNow = {shiftReg[BYTE_W-2:0], stb.bitVal};
  assign selCode = byteNow[BYTE_W-1 -: SEL_W];
  assign payload = byteNow[PAY_W-1:0];
  assign addrOk  = (shiftReg[BYTE_W-1:1] == {DEV_HI, addrStrap}) && !shiftReg[0];
  assign addrRw  = shiftReg[0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [PAY_W-1:0] MASK = keepMask(g);
    logic [PAY_W-1:0] valQ, pendQ;
    logic pendV, wrHit;

    assign wrHit = stb.commit && (selCode == SEL_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        valQ  <= '0;
        pendQ <= '0;
        pendV <= 1'b0;
      end else if (holdApply) begin
        if (wrHit) begin
          pendQ <= payload & MASK;
          pendV <= 1'b1;
        end
      end else begin
        pendV <= 1'b0;
        if (wrHit) valQ <= payload & MASK;
        else if (pendV) valQ <= pendQ;
      end
    end

    assign regFlat[g*PAY_W +: PAY_W] = valQ;
    assign pendVec[g] = pendV;
  end

  // R8: outputs frozen while hold is asserted
  a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rstN)
    holdApply |=> $stable(regFlat));

  // R7: an unused register code changes nothing when no flush is due
  a_r7_unused_code: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && int'(selCode) >= NUM_REGS && pendVec == '0) |=> $stable(regFlat));
endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave
  import i2cw_pkg::*;
#(
  parameter logic [ADDR_W-2:0] DEV_HI      = 6'b111110,
  parameter int                SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             addrStrap,
  input  logic             holdApply,
  output logic             sdaPullEn,
  output logic             powerOn,
  output logic             in2Sel,
  output logic             in1Sel,
  output logic             diagEn,
  output logic             diagCont,
  output logic             faultClr,
  output logic             ilimMode,
  output logic [PAY_W-1:0] faultMask,
  output logic [PAY_W-1:0] vol1,
  output logic [PAY_W-1:0] vol2
);
  strobe_t stb;
  logic addrOk, addrRw;
  logic [NUM_REGS*PAY_W-1:0] regFlat;
  logic [PAY_W-1:0] modeQ, diagQ;

  i2cw_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrOk(addrOk), .addrRw(addrRw), .stb(stb), .sdaPullEn(sdaPullEn)
  );

  i2cw_regs #(.DEV_HI(DEV_HI)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .addrStrap(addrStrap),
    .holdApply(holdApply), .addrOk(addrOk), .addrRw(addrRw), .regFlat(regFlat)
  );

  assign modeQ     = regFlat[REG_MODE*PAY_W +: PAY_W];
  assign diagQ     = regFlat[REG_DIAG*PAY_W +: PAY_W];
  assign faultMask = regFlat[REG_MASK*PAY_W +: PAY_W];
  assign vol1      = regFlat[REG_VOL1*PAY_W +: PAY_W];
  assign vol2      = regFlat[REG_VOL2*PAY_W +: PAY_W];
  assign powerOn   = modeQ[4];
  assign in2Sel    = modeQ[3];
  assign in1Sel    = modeQ[2];
  assign diagEn    = diagQ[4];
  assign diagCont  = diagQ[3];
  assign faultClr  = diagQ[2];
  assign ilimMode  = diagQ[1];
endmodule

// File: tb/tb_i2cw_slave.sv
module tb_i2cw_slave;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic addrStrap = 1'b0, holdApply = 1'b0;
  logic sdaIn;
  logic sdaPullEn, powerOn, in2Sel, in1Sel, diagEn, diagCont, faultClr, ilimMode;
  logic [4:0] faultMask, vol1, vol2;

  always #5 clk = ~clk;

  assign sdaIn = sdaM & ~sdaPullEn;

  i2cw_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaIn), .addrStrap(addrStrap),
    .holdApply(holdApply), .sdaPullEn(sdaPullEn), .powerOn(powerOn), .in2Sel(in2Sel),
    .in1Sel(in1Sel), .diagEn(diagEn), .diagCont(diagCont), .faultClr(faultClr),
    .ilimMode(ilimMode), .faultMask(faultMask), .vol1(vol1), .vol2(vol2)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;

  // behavioural model of register state
  int expReg[5], pendReg[5];
  bit pendV[5];
  int cd = 0, evCode = 0, evPay = 0;
  logic prevPull = 1'b0;

  function automatic int maskOf(int idx, int v);
    if (idx == 0) return v & 'h1C;
    if (idx == 1) return v & 'h1E;
    return v & 'h1F;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 5; i++) begin expReg[i] = 0; pendReg[i] = 0; pendV[i] = 0; end
      cd = 0;
    end else begin
      if (!holdApply)
        for (int i = 0; i < 5; i++)
          if (pendV[i]) begin expReg[i] = pendReg[i]; pendV[i] = 0; end
      if (cd == 1 && evCode < 5) begin
        if (holdApply) begin pendReg[evCode] = maskOf(evCode, evPay); pendV[evCode] = 1; end
        else expReg[evCode] = maskOf(evCode, evPay);
      end
      if (cd > 0) cd = cd - 1;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int actOf(int idx);
    case (idx)
      0: return {27'd0, powerOn, in2Sel, in1Sel, 2'b00};
      1: return {27'd0, diagEn, diagCont, faultClr, ilimMode, 1'b0};
      2: return int'(faultMask);
      3: return int'(vol1);
      default: return int'(vol2);
    endcase
  endfunction

  // per-clock comparison against the model, plus R11 pull timing
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int i = 0; i < 5; i++) chk("R4 R8 model register", actOf(i), expReg[i]);
      if (sdaPullEn !== prevPull) chk("R11 pull changes with SCL low", int'(sclM), 0);
      prevPull = sdaPullEn;
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; waitN(Q);
    sclM = 1'b1; waitN(Q);
    sdaM = 1'b0; waitN(Q);
    sclM = 1'b0; waitN(Q);
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; waitN(Q);
    sclM = 1'b1; waitN(Q);
    sdaM = 1'b1; waitN(Q);
  endtask

  task automatic sendBit(input logic b, input bit mark, input int code, input int pay);
    sdaM = b; waitN(Q);
    sclM = 1'b1;
    if (mark) begin evCode = code; evPay = pay; cd = 3; end
    waitN(Q);
    sclM = 1'b0; waitN(Q);
  endtask

  task automatic ackBit(input bit expAck, input string tag);
    sdaM = 1'b1; waitN(Q);
    sclM = 1'b1; waitN(2);
    chk(tag, int'(sdaPullEn), int'(expAck));
    waitN(Q - 2);
    sclM = 1'b0; waitN(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, input bit markLast);
    for (int i = 7; i >= 0; i--)
      sendBit(v[i], markLast && i == 0, int'(v[7:5]), int'(v[4:0]));
  endtask

  task automatic xfer(input logic [6:0] a, input logic rw, input logic [7:0] d,
                      input bit addrAck, input string tag, input bit extra);
    i2cStart();
    sendByte({a, rw}, 1'b0);
    ackBit(addrAck, {tag, " address ack"});
    sendByte(d, addrAck);
    ackBit(addrAck, {tag, " data ack"});
    if (extra) begin
      sendByte(8'b000_01100, 1'b0);
      ackBit(1'b0, "R10 extra byte not acked");
    end
    i2cStop();
    waitN(6);
  endtask

  task automatic partial(input logic [6:0] a, input bit stopIt);
    i2cStart();
    sendByte({a, 1'b0}, 1'b0);
    ackBit(1'b1, "R9 address ack before abort");
    sendBit(1'b0, 0, 0, 0);
    sendBit(1'b1, 0, 0, 0);
    sendBit(1'b1, 0, 0, 0);
    if (stopIt) begin i2cStop(); waitN(6); end
  endtask

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    waitN(4);
    chk("R1 reset pull", int'(sdaPullEn), 0);
    for (int i = 0; i < 5; i++) chk("R1 reset register", actOf(i), 0);
    rstN = 1'b1;
    waitN(4);

    // R5 mode write: power on, both inputs, reserved bits ignored
    xfer(7'b1111100, 1'b0, 8'b000_11111, 1'b1, "R2 R4", 1'b0);
    chk("R5 powerOn", int'(powerOn), 1);
    chk("R5 in2Sel", int'(in2Sel), 1);
    chk("R5 in1Sel", int'(in1Sel), 1);

    // R6 diagnostic fields
    xfer(7'b1111100, 1'b0, 8'b001_11111, 1'b1, "R4 diag", 1'b0);
    chk("R6 diag fields", {28'd0, diagEn, diagCont, faultClr, ilimMode}, 'hF);
    xfer(7'b1111100, 1'b0, 8'b001_01011, 1'b1, "R4 diag", 1'b0);
    chk("R6 diag fields second", {28'd0, diagEn, diagCont, faultClr, ilimMode}, 'h5);

    // R2 wrong address ignored
    xfer(7'b1111101, 1'b0, 8'b011_10101, 1'b0, "R2 mismatch", 1'b0);
    chk("R2 mismatch vol1 unchanged", int'(vol1), 0);
    xfer(7'b0111100, 1'b0, 8'b011_10101, 1'b0, "R2 mismatch high bit", 1'b0);
    chk("R2 mismatch high bit vol1", int'(vol1), 0);

    // R3 read direction
    xfer(7'b1111100, 1'b1, 8'b011_10101, 1'b0, "R3 read", 1'b0);
    chk("R3 read vol1 unchanged", int'(vol1), 0);

    // R4 remaining registers
    xfer(7'b1111100, 1'b0, 8'b010_10110, 1'b1, "R4 mask", 1'b0);
    xfer(7'b1111100, 1'b0, 8'b011_00011, 1'b1, "R4 vol1", 1'b0);
    xfer(7'b1111100, 1'b0, 8'b100_11111, 1'b1, "R4 vol2", 1'b0);
    chk("R4 faultMask", int'(faultMask), 'h16);
    chk("R4 vol1", int'(vol1), 3);
    chk("R4 vol2", int'(vol2), 31);

    // R7 unused codes
    xfer(7'b1111100, 1'b0, 8'b101_11111, 1'b1, "R7 code 5", 1'b0);
    xfer(7'b1111100, 1'b0, 8'b111_00000, 1'b1, "R7 code 7", 1'b0);
    chk("R7 vol2 unchanged", int'(vol2), 31);
    chk("R7 mask unchanged", int'(faultMask), 'h16);

    // R2 strap selects address LSB
    addrStrap = 1'b1;
    waitN(4);
    xfer(7'b1111101, 1'b0, 8'b100_00100, 1'b1, "R2 strap high", 1'b0);
    xfer(7'b1111100, 1'b0, 8'b100_01111, 1'b0, "R2 strap high old address", 1'b0);
    chk("R2 strap vol2", int'(vol2), 4);
    addrStrap = 1'b0;
    waitN(4);

    // R9 abort by STOP, then abort by repeated START
    partial(7'b1111100, 1'b1);
    chk("R9 stop abort vol1", int'(vol1), 3);
    partial(7'b1111100, 1'b0);
    xfer(7'b1111100, 1'b0, 8'b011_01010, 1'b1, "R9 after restart", 1'b0);
    chk("R9 restart vol1", int'(vol1), 10);

    // R10 second data byte ignored
    xfer(7'b1111100, 1'b0, 8'b000_10000, 1'b1, "R10 first byte", 1'b1);
    chk("R10 mode", {29'd0, powerOn, in2Sel, in1Sel}, 'h4);

    // R8 hold defers, last write wins
    holdApply = 1'b1;
    xfer(7'b1111100, 1'b0, 8'b011_00101, 1'b1, "R8 held", 1'b0);
    xfer(7'b1111100, 1'b0, 8'b011_01001, 1'b1, "R8 held", 1'b0);
    xfer(7'b1111100, 1'b0, 8'b010_00001, 1'b1, "R8 held", 1'b0);
    chk("R8 vol1 held", int'(vol1), 10);
    chk("R8 mask held", int'(faultMask), 'h16);
    holdApply = 1'b0;
    waitN(1);
    chk("R8 vol1 applied", int'(vol1), 9);
    chk("R8 mask applied", int'(faultMask), 1);
    waitN(10);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule